// File: doc/BRIEF.md
# Serial receive FIFO with fill trigger

This block holds the receive half of a serial controller's register interface. Bytes already recovered by an external deserializer arrive on a one-cycle valid strobe. They are stored in a 16-entry byte queue, which software empties through a receive-data register. A fill threshold decides when the block reports "receive full" and raises its interrupt. Software picks one of four thresholds through the FIFO-control register. A separate pulse input records a detected line break.

Software reaches the block through a simple register port. A write takes one cycle. Read data is combinational from the current state, and a read strobe on the receive-data offset consumes the byte it returns. The interrupt is a level: once raised, it stays asserted until software clears it. Software can clear it through the control register or the status register.

Top module: `rx_fifo_trig`

## Requirements
- R1: Register offsets are fixed as follows: control at 0x08, status at 0x10, receive data at 0x14, FIFO control at 0x18 and port at 0x20. Any other offset reads 0x00.
- R2: The queue holds up to 16 bytes, which are returned in arrival order. The write and read positions wrap after the last entry.
- R3: FIFO-control bits [7:6] select the trigger: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. After reset the register is 0x00, so the trigger is 1.
- R4: A FIFO-control write with bit 1 set empties the queue and clears both the receive-full and data-ready flags. A byte strobed in the same cycle is dropped.
- R5: A strobed byte is stored only while control bit 4 is set. Otherwise it leaves no trace.
- R6: A byte that arrives while 16 bytes are held is discarded.
- R7: When a stored byte brings the occupancy to the trigger or above, receive-full is set. If control bit 6 is also set, the interrupt is raised.
- R8: Reading offset 0x14 with data present returns the oldest byte and removes it. If the occupancy then drops below the trigger, receive-full clears.
- R9: Reading offset 0x14 with the queue empty returns 0x00 and changes nothing.
- R10: The interrupt is a level. It drops on a control write with bit 6 clear, or on a status write with bit 0 or bit 1 clear. A status write with bit 1 clear also clears receive-full, and one with bit 0 clear also clears data-ready.
- R11: The status register reads as follows: bit 0 is data-ready, which is set by every stored byte; bit 1 is receive-full; bit 4 is break. A break pulse sets bit 4, and a status write with bit 4 clear clears it. All other bits read 0.
- R12: The control register stores the written value ANDed with 0xFA, and the port register stores the written value ANDed with 0xF3. Both read back the stored value.
- R13: A stored byte and a consumed byte in the same cycle leave the occupancy unchanged. Receive-full is then judged on that unchanged occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| brk_det | input | 1 | Break detected pulse |
| rx_irq | output | 1 | Receive interrupt, level |

## Verification
The bench builds the block with its defaults: a depth of 16 and a 6-bit offset. With these defaults the largest trigger (14) and the overflow point (16) are both reached within a few dozen strobes. Filling the queue completely from an empty state forces the write position through its wrap. The bench then drains every entry and compares each byte against a queue of expected data. The same run exercises each trigger level at its exact crossing point, and it also covers the same-cycle store and consume case.

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig #(
  parameter int DEPTH = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          brk_det,
  output logic          rx_irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h08);
  localparam logic [AW-1:0] OFS_STAT = AW'(8'h10);
  localparam logic [AW-1:0] OFS_DATA = AW'(8'h14);
  localparam logic [AW-1:0] OFS_FCR  = AW'(8'h18);
  localparam logic [AW-1:0] OFS_PORT = AW'(8'h20);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_n, trig;
  logic [7:0]    ctrl_q, fcr_q, port_q;
  logic          full_q, dr_q, brk_q, irq_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  wire wr_ctrl = reg_wr && reg_addr == OFS_CTRL;
  wire wr_stat = reg_wr && reg_addr == OFS_STAT;
  wire wr_fcr  = reg_wr && reg_addr == OFS_FCR;
  wire wr_port = reg_wr && reg_addr == OFS_PORT;
  wire flush   = wr_fcr && reg_wdata[1];
  wire pop     = reg_rd && reg_addr == OFS_DATA && cnt != '0 && !flush;
  wire push    = rx_valid && ctrl_q[4] && cnt != CW'(DEPTH) && !flush;
  wire hit     = cnt_n >= trig;

  always_comb begin
    case (fcr_q[7:6])
      2'b00:   trig = CW'(1);
      2'b01:   trig = CW'(4);
      2'b10:   trig = CW'(8);
      default: trig = CW'(14);
    endcase
  end

  always_comb begin
    cnt_n = cnt;
    if (push && !pop) cnt_n = cnt + CW'(1);
    else if (pop && !push) cnt_n = cnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      ctrl_q <= '0; fcr_q <= '0; port_q <= '0;
      full_q <= 1'b0; dr_q <= 1'b0; brk_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata & 8'hFA;
      if (wr_port) port_q <= reg_wdata & 8'hF3;
      if (wr_fcr)  fcr_q  <= reg_wdata;

      if (flush) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (push) wp <= nxt(wp);
        if (pop)  rp <= nxt(rp);
        cnt <= cnt_n;
      end

      if (flush || (wr_stat && !reg_wdata[1])) full_q <= 1'b0;
      if (pop && !hit)  full_q <= 1'b0;
      if (push && hit)  full_q <= 1'b1;

      if (flush || (wr_stat && !reg_wdata[0])) dr_q <= 1'b0;
      if (push) dr_q <= 1'b1;

      if (wr_stat && !reg_wdata[4]) brk_q <= 1'b0;
      if (brk_det) brk_q <= 1'b1;

      if ((wr_ctrl && !reg_wdata[6]) ||
          (wr_stat && !(reg_wdata[1] && reg_wdata[0]))) irq_q <= 1'b0;
      if (push && hit && ctrl_q[6]) irq_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = ctrl_q;
      OFS_STAT: reg_rdata = {3'b000, brk_q, 2'b00, full_q, dr_q};
      OFS_DATA: reg_rdata = (cnt != '0) ? mem[rp] : 8'h00;
      OFS_FCR:  reg_rdata = fcr_q;
      OFS_PORT: reg_rdata = port_q;
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign rx_irq = irq_q;
endmodule

// File: rtl/rx_fifo_trig_chk.sv
module rx_fifo_trig_chk #(
  parameter int DEPTH = 16,
  parameter int AW = 6,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          rx_valid,
  input logic [CW-1:0] cnt,
  input logic [7:0]    ctrl_q,
  input logic          full_q,
  input logic          rx_irq
);
  localparam logic [AW-1:0] C_CTRL = AW'(8'h08);
  localparam logic [AW-1:0] C_DATA = AW'(8'h14);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R6
  AST_RX_OFF_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ctrl_q[4]) |=> cnt <= $past(cnt)); // R5
  AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> full_q); // R7
  AST_RIE_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == C_CTRL && !reg_wdata[6] && !rx_valid) |=> !rx_irq); // R10
  AST_CTRL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == C_CTRL) |=> ctrl_q == ($past(reg_wdata) & 8'hFA)); // R12
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == C_DATA && cnt == '0 && !rx_valid) |=> cnt == '0); // R9
endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rx_valid(rx_valid),
  .cnt(cnt), .ctrl_q(ctrl_q), .full_q(full_q), .rx_irq(rx_irq)
);

// File: tb/tb_rx_fifo_trig.sv
module tb_rx_fifo_trig;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CTRL = 6'h08, A_STAT = 6'h10, A_DATA = 6'h14,
                         A_FCR = 6'h18, A_PORT = 6'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, rx_valid = 1'b0, brk_det = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, rx_data = '0, reg_rdata, d;
  logic rx_irq;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  logic [7:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_trig dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .brk_det(brk_det), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    reg_rd = 1'b1; reg_addr = a; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] v, input bit accepted);
    rx_valid = 1'b1; rx_data = v;
    if (accepted) expq.push_back(v);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pop_cmp(input string req);
    logic [7:0] e;
    rd(A_DATA, d);
    e = (expq.size() != 0) ? expq.pop_front() : 8'h00;
    chk(req, d, e);
  endtask

  task automatic stat(input string req, input logic [7:0] e);
    rd(A_STAT, d); chk(req, d, e);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: R11 R3
    stat("R11 reset status", 8'h00);
    rd(A_FCR, d); chk("R3 reset trigger field", d, 8'h00);
    chk("R10 reset irq", {7'b0, rx_irq}, 8'h00);
    // R5 receive disabled
    for (int i = 0; i < 3; i++) push(8'h30 + 8'(i), 1'b0);
    stat("R5 disabled leaves status", 8'h00);
    pop_cmp("R9 empty read returns zero");
    // trigger 1 default, R7 R8 R10
    wr(A_CTRL, 8'h50);
    push(8'hA1, 1'b1);
    stat("R7 full at trigger 1", 8'h03);
    chk("R7 irq at trigger 1", {7'b0, rx_irq}, 8'h01);
    pop_cmp("R8 oldest byte");
    stat("R8 full clears below trigger", 8'h01);
    chk("R10 irq holds as level", {7'b0, rx_irq}, 8'h01);
    wr(A_STAT, 8'hFE);
    chk("R10 status bit0 clear drops irq", {7'b0, rx_irq}, 8'h00);
    stat("R10 data-ready cleared", 8'h00);
    // trigger 4, R3
    wr(A_FCR, 8'h40);
    for (int i = 0; i < 3; i++) push(8'h40 + 8'(i), 1'b1);
    stat("R3 below trigger 4", 8'h01);
    chk("R3 no irq below 4", {7'b0, rx_irq}, 8'h00);
    push(8'h43, 1'b1);
    stat("R3 full at 4", 8'h03);
    chk("R7 irq at 4", {7'b0, rx_irq}, 8'h01);
    wr(A_CTRL, 8'h10);
    chk("R10 ctrl bit6 clear drops irq", {7'b0, rx_irq}, 8'h00);
    stat("R10 full survives ctrl write", 8'h03);
    pop_cmp("R8 pop at 4");
    stat("R8 full clears at 3", 8'h01);
    for (int i = 0; i < 3; i++) pop_cmp("R2 order");
    wr(A_CTRL, 8'h50);
    // trigger 8 and flush, R3 R4
    wr(A_FCR, 8'h80);
    for (int i = 0; i < 7; i++) push(8'h50 + 8'(i), 1'b1);
    stat("R3 below trigger 8", 8'h01);
    push(8'h57, 1'b1);
    stat("R3 full at 8", 8'h03);
    wr(A_FCR, 8'h82);
    expq.delete();
    stat("R4 flush clears flags", 8'h00);
    pop_cmp("R4 flushed queue is empty");
    wr(A_STAT, 8'hFC);
    chk("R10 status clear drops irq", {7'b0, rx_irq}, 8'h00);
    // trigger 14, overflow, wrap, R6 R2
    wr(A_FCR, 8'hC0);
    for (int i = 0; i < 13; i++) push(8'h60 + 8'(i), 1'b1);
    stat("R3 below trigger 14", 8'h01);
    chk("R3 no irq below 14", {7'b0, rx_irq}, 8'h00);
    push(8'h6D, 1'b1);
    stat("R3 full at 14", 8'h03);
    chk("R7 irq at 14", {7'b0, rx_irq}, 8'h01);
    push(8'h6E, 1'b1);
    push(8'h6F, 1'b1);
    push(8'hEE, 1'b0);
    for (int i = 0; i < 16; i++) pop_cmp("R6 R2 full drain order");
    stat("R8 full cleared after drain", 8'h01);
    pop_cmp("R9 read after drain");
    wr(A_STAT, 8'hFC);
    stat("R10 flags cleared", 8'h00);
    // simultaneous store and consume, R13
    wr(A_FCR, 8'h00);
    push(8'h71, 1'b1);
    rx_valid = 1'b1; rx_data = 8'h72; expq.push_back(8'h72);
    reg_rd = 1'b1; reg_addr = A_DATA; #1 d = reg_rdata;
    chk("R13 concurrent read data", d, expq.pop_front());
    @(negedge clk); rx_valid = 1'b0; reg_rd = 1'b0;
    stat("R13 occupancy unchanged keeps full", 8'h03);
    pop_cmp("R13 second byte");
    stat("R13 full clears at empty", 8'h01);
    wr(A_STAT, 8'hFC);
    // break, R11
    brk_det = 1'b1; @(negedge clk); brk_det = 1'b0;
    stat("R11 break flag", 8'h10);
    wr(A_STAT, 8'hEF);
    stat("R11 break cleared", 8'h00);
    // masks and offsets, R12 R1
    wr(A_CTRL, 8'hFF);
    rd(A_CTRL, d); chk("R12 ctrl mask", d, 8'hFA);
    wr(A_PORT, 8'hFF);
    rd(A_PORT, d); chk("R12 port mask", d, 8'hF3);
    rd(6'h04, d); chk("R1 unmapped offset", d, 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule